// File: doc/BRIEF.md
# Wake-up External Interrupt Controller

This block collects 28 asynchronous external interrupt lines and presents them to a processor as four grouped interrupt requests. Every line is first brought into the clock domain by a synchroniser, then examined by a trigger detector that senses a low level, a high level, a falling edge, a rising edge or either edge. Detected events latch into a per-line pending bit, which software clears by writing ones. A per-line mask keeps a pending line from reaching its output.

Two adjacent lines share one 4-bit trigger selector. The 14 selectors are spread over two configuration words. The outputs cover lines of unequal count: the first output serves 4 lines and each of the other three serves 8 lines. Software reaches the block through a plain word-addressed read/write port. A write takes effect on the clock edge. A read returns the addressed word combinationally.

Top module: `wkint_ctrl`

## Requirements
- R1: After reset both configuration words read 0, the mask word reads 0x0FFFFFFF (every line blocked), the pending word reads 0 and all four outputs are low. The synchroniser stages reset to the idle-high value, so idle-high inputs raise no event.
- R2: An input change that is applied between two clock edges sets its pending bit at the third rising edge after the change, and not at an earlier edge.
- R3: Trigger code 2 latches on a falling input, code 4 on a rising input and code 6 on either edge. An edge code never latches on a steady input.
- R4: Line i uses the selector at bits [4*((i mod 16)/2)+3 : 4*((i mod 16)/2)] of word address 0 for i < 16, and of word address 1 for i ≥ 16. One selector therefore governs lines 2k and 2k+1 together.
- R5: Code 0 latches while the synchronised input is low and code 1 latches while it is high. A level that is still active sets the pending bit again in the cycle after a clear.
- R6: A write to word address 3 clears each pending bit whose data bit is 1. Bits written as 0 keep their value. Without such a write a pending bit never clears.
- R7: A mask bit of 1 (word address 2, bit i for line i) keeps line i from its output without clearing its pending bit. A mask bit of 0 lets the line through.
- R8: Output 0 is high when any of lines 0–3 is pending and unmasked. Output 1 does the same for lines 4–11, output 2 for lines 12–19 and output 3 for lines 20–27.
- R9: When an event and a clearing write hit the same line in the same cycle, the pending bit stays set.
- R10: Selector codes 3, 5, 7 and 8–15 disable their lines: no input activity sets pending.
- R11: Reads return the stored state. Configuration bits beyond the 14 selectors and the mask and pending bits above 27 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 28 | Asynchronous external interrupt lines |
| reg_addr | input | 2 | Word address: 0 config low, 1 config high, 2 mask, 3 pending |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 4 | Grouped interrupt requests |

## Verification
A pending bit that is stuck or lost shows up on the group output within one cycle, provided the line is unmasked. It also shows in the pending word, which the bench reads after every stimulus. A selector decoded from the wrong field or word makes the wrong line latch, or none at all. This is visible three edges after the input moves, and the bench checks both members of a selector pair. Errors in collision priority and in level re-triggering appear in the very next read after the clearing write, so the bench times that write to the exact edge on which the synchronised event arrives.

// File: rtl/wkint_pkg.sv
package wkint_pkg;
   localparam int TRIG_W = 4;

   typedef enum logic [TRIG_W-1:0] {
      TRG_LOW  = 4'd0,
      TRG_HIGH = 4'd1,
      TRG_FALL = 4'd2,
      TRG_RISE = 4'd4,
      TRG_BOTH = 4'd6
   } trig_e;

   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] ADDR_CFG_LO = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_CFG_HI = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd2;
   localparam logic [ADDR_W-1:0] ADDR_PEND   = 2'd3;
endpackage

// File: rtl/wkint_sync.sv
module wkint_sync #(
   parameter int W       = 28,
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] prev_o
);
   logic [W-1:0] chain_q [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k <= STAGES; k++) chain_q[k] <= {W{RST_VAL}};
      end else begin
         chain_q[0] <= async_i;
         for (int k = 1; k <= STAGES; k++) chain_q[k] <= chain_q[k-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];
   assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/wkint_detect.sv
module wkint_detect
   import wkint_pkg::*;
(
   input  logic              cur_i,
   input  logic              prev_i,
   input  logic [TRIG_W-1:0] code_i,
   output logic              event_o
);
   always_comb begin
      case (code_i)
         TRG_LOW:  event_o = ~cur_i;
         TRG_HIGH: event_o = cur_i;
         TRG_FALL: event_o = prev_i & ~cur_i;
         TRG_RISE: event_o = ~prev_i & cur_i;
         TRG_BOTH: event_o = prev_i ^ cur_i;
         default:  event_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/wkint_pend.sv
module wkint_pend #(
   parameter int W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] event_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] pend_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= (pend_o & ~clr_i) | event_i;
   end
endmodule

// File: rtl/wkint_group_or.sv
module wkint_group_or #(
   parameter int FIRST_LINES = 4,
   parameter int GRP_LINES   = 8,
   parameter int NUM_OUT     = 4,
   localparam int NUM_LINES  = FIRST_LINES + GRP_LINES * (NUM_OUT - 1)
) (
   input  logic [NUM_LINES-1:0] active_i,
   output logic [NUM_OUT-1:0]   irq_o
);
   for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
      localparam int LO  = (g == 0) ? 0 : FIRST_LINES + (g - 1) * GRP_LINES;
      localparam int CNT = (g == 0) ? FIRST_LINES : GRP_LINES;
      assign irq_o[g] = |active_i[LO +: CNT];
   end
endmodule

// File: rtl/wkint_ctrl.sv
module wkint_ctrl
   import wkint_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int LINES_PER_SEL = 2,
   parameter int FIRST_LINES   = 4,
   parameter int GRP_LINES     = 8,
   parameter int NUM_OUT       = 4,
   parameter int SYNC_STAGES   = 2,
   parameter bit IN_IDLE       = 1'b1,
   localparam int NUM_LINES    = FIRST_LINES + GRP_LINES * (NUM_OUT - 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] ext_in,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic [NUM_OUT-1:0]   irq
);
   localparam int SEL_PER_WORD   = DATA_W / TRIG_W;
   localparam int LINES_PER_WORD = SEL_PER_WORD * LINES_PER_SEL;
   localparam int NUM_SEL        = (NUM_LINES + LINES_PER_SEL - 1) / LINES_PER_SEL;
   localparam int CFG_BITS       = NUM_SEL * TRIG_W;

   if ((DATA_W % TRIG_W) != 0 || NUM_LINES > DATA_W ||
       NUM_LINES > 2 * LINES_PER_WORD || SYNC_STAGES < 2 ||
       LINES_PER_SEL < 1 || NUM_OUT < 1) begin : g_bad_params
      $error("wkint_ctrl: parameter set not supported");
   end

   logic [NUM_LINES-1:0] sync_w, prev_w, event_w, clr_w, pend_q, mask_q;
   logic [TRIG_W-1:0]    sel_q [NUM_SEL];
   logic [2*DATA_W-1:0]  cfg_flat;

   wkint_sync #(
      .W       (NUM_LINES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IN_IDLE)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ext_in),
      .sync_o  (sync_w),
      .prev_o  (prev_w)
   );

   // trigger selectors: one field per pair of lines, split over two words
   for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
      localparam int WORD = s / SEL_PER_WORD;
      localparam int OFS  = (s % SEL_PER_WORD) * TRIG_W;
      localparam logic [ADDR_W-1:0] SEL_ADDR = (WORD == 0) ? ADDR_CFG_LO : ADDR_CFG_HI;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              sel_q[s] <= '0;
         else if (reg_wr && reg_addr == SEL_ADDR) sel_q[s] <= reg_wdata[OFS +: TRIG_W];
      end

      assign cfg_flat[s*TRIG_W +: TRIG_W] = sel_q[s];
   end

   if (CFG_BITS < 2 * DATA_W) begin : g_cfg_pad
      assign cfg_flat[2*DATA_W-1:CFG_BITS] = '0;
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      wkint_detect u_det (
         .cur_i   (sync_w[i]),
         .prev_i  (prev_w[i]),
         .code_i  (sel_q[i / LINES_PER_SEL]),
         .event_o (event_w[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mask_q <= '1;
      else if (reg_wr && reg_addr == ADDR_MASK) mask_q <= reg_wdata[NUM_LINES-1:0];
   end

   assign clr_w = (reg_wr && reg_addr == ADDR_PEND) ? reg_wdata[NUM_LINES-1:0] : '0;

   wkint_pend #(.W(NUM_LINES)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_i (event_w),
      .clr_i   (clr_w),
      .pend_o  (pend_q)
   );

   wkint_group_or #(
      .FIRST_LINES (FIRST_LINES),
      .GRP_LINES   (GRP_LINES),
      .NUM_OUT     (NUM_OUT)
   ) u_or (
      .active_i (pend_q & ~mask_q),
      .irq_o    (irq)
   );

   always_comb begin
      case (reg_addr)
         ADDR_CFG_LO: reg_rdata = cfg_flat[DATA_W-1:0];
         ADDR_CFG_HI: reg_rdata = cfg_flat[2*DATA_W-1:DATA_W];
         ADDR_MASK:   reg_rdata = DATA_W'(mask_q);
         default:     reg_rdata = DATA_W'(pend_q);
      endcase
   end
endmodule

// File: rtl/wkint_ctrl_chk.sv
module wkint_ctrl_chk
   import wkint_pkg::*;
#(
   parameter int NUM_LINES = 28,
   parameter int NUM_OUT   = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_wr,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic [NUM_LINES-1:0] wdata,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] pend_q,
   input logic [NUM_OUT-1:0]   irq
);
   // R7: a fully set mask keeps every output low
   p_all_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> (irq == '0));

   // R8: no output without a pending line
   p_no_pend_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == '0) |-> (irq == '0));

   // R6: bits written as zero survive a clearing write
   p_zero_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_PEND) |=>
      (($past(pend_q) & ~$past(wdata) & ~pend_q) == '0));

   // R6: without a clearing write nothing pending is lost
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == ADDR_PEND) |=> (($past(pend_q) & ~pend_q) == '0));

   // R11: a mask write is stored as written
   p_mask_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_MASK) |=> (mask_q == $past(wdata)));
endmodule

bind wkint_ctrl wkint_ctrl_chk #(
   .NUM_LINES (NUM_LINES),
   .NUM_OUT   (NUM_OUT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .wdata    (reg_wdata[NUM_LINES-1:0]),
   .mask_q   (mask_q),
   .pend_q   (pend_q),
   .irq      (irq)
);

// File: tb/wkint_ctrl_tb.sv
`timescale 1ns/1ps
module wkint_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [27:0] ext_in = '1;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  irq;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] cfg_sh [2];

   always #2.5 clk = ~clk;

   wkint_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_in    (ext_in),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic set_pair(input int pair, input logic [3:0] code);
      int w = pair / 8;
      cfg_sh[w][(pair % 8)*4 +: 4] = code;
      wr(w[1:0], cfg_sh[w]);
   endtask

   function automatic logic [3:0] grp_bit(input int line);
      int g = (line < 4) ? 0 : (line - 4) / 8 + 1;
      return 4'(1 << g);
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(2'd0, d); chk("R1 cfg lo", d, 32'h0);
      rd(2'd1, d); chk("R1 cfg hi", d, 32'h0);
      rd(2'd2, d); chk("R1 mask", d, 32'h0FFF_FFFF);
      settle();
      rd(2'd3, d); chk("R1 pending (idle-high inputs)", d, 32'h0);
      chk("R1 irq", {28'h0, irq}, 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R11 cfg lo readback", d, 32'hFFFF_FFFF);
      wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R11 cfg hi unused bits", d, 32'h00FF_FFFF);
      wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); chk("R11 mask unused bits", d, 32'h0FFF_FFFF);
      wr(2'd2, 32'h0000_0000); rd(2'd2, d); chk("R11 mask zero", d, 32'h0);
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd0, 32'h0); wr(2'd1, 32'h0);
      cfg_sh[0] = '0; cfg_sh[1] = '0;
      rd(2'd1, d); chk("R11 cfg hi cleared", d, 32'h0);
   endtask

   task automatic t_latency();
      logic [31:0] d;
      set_pair(1, 4'd2);
      settle();
      wr(2'd3, 32'hFFFF_FFFF);
      ext_in[2] = 1'b0;
      @(negedge clk);
      rd(2'd3, d); chk("R2 not yet pending after two edges", d, 32'h0);
      rd(2'd3, d); chk("R2 pending after third edge", d, 32'h0000_0004);
      ext_in[2] = 1'b1;
      settle();
      rd(2'd3, d); chk("R3 falling code ignores rise", d, 32'h0000_0004);
      wr(2'd3, 32'hFFFF_FFFF);
   endtask

   task automatic t_edge_codes();
      logic [31:0] d;
      logic [3:0] codes [3] = '{4'd2, 4'd4, 4'd6};
      for (int k = 0; k < 3; k++) begin
         logic fall_exp = (codes[k] != 4'd4);
         logic rise_exp = (codes[k] != 4'd2);
         set_pair(10, codes[k]);
         settle();
         wr(2'd3, 32'hFFFF_FFFF);
         settle();
         rd(2'd3, d); chk($sformatf("R3 code %0d steady", codes[k]), d, 32'h0);
         ext_in[21] = 1'b0; settle();
         rd(2'd3, d); chk($sformatf("R3 code %0d fall line21", codes[k]), d, {10'h0, fall_exp, 21'h0});
         wr(2'd3, 32'hFFFF_FFFF);
         ext_in[21] = 1'b1; settle();
         rd(2'd3, d); chk($sformatf("R3 code %0d rise line21", codes[k]), d, {10'h0, rise_exp, 21'h0});
         wr(2'd3, 32'hFFFF_FFFF);
      end
      set_pair(10, 4'd2);
      ext_in[20] = 1'b0; settle();
      rd(2'd3, d); chk("R4 pair partner line20 shares selector", d, 32'h0010_0000);
      ext_in[20] = 1'b1; settle();
      wr(2'd3, 32'hFFFF_FFFF);
   endtask

   task automatic t_level();
      logic [31:0] d;
      set_pair(13, 4'd1);
      settle();
      rd(2'd3, d); chk("R5 R4 high level lines 26 and 27", d, 32'h0C00_0000);
      wr(2'd3, 32'h0400_0000);
      rd(2'd3, d); chk("R5 active level sets again after clear", d, 32'h0C00_0000);
      set_pair(13, 4'd3);
      wr(2'd3, 32'hFFFF_FFFF);
      settle();
      rd(2'd3, d); chk("R10 code 3 disabled", d, 32'h0);
      set_pair(13, 4'd7);
      ext_in[27] = 1'b0; settle(); ext_in[27] = 1'b1; settle();
      rd(2'd3, d); chk("R10 code 7 disabled on toggle", d, 32'h0);
      set_pair(13, 4'hF);
      ext_in[26] = 1'b0; settle();
      rd(2'd3, d); chk("R10 code 15 disabled at low level", d, 32'h0);
      ext_in[26] = 1'b1;
      set_pair(13, 4'd0);
      settle();
      ext_in[9] = 1'b0; settle();
      rd(2'd3, d); chk("R5 low level line 9", d, 32'h0000_0200);
      ext_in[9] = 1'b1; settle();
      wr(2'd3, 32'h0000_0200);
      rd(2'd3, d); chk("R6 clear after level released", d, 32'h0);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      set_pair(0, 4'd2);
      settle();
      ext_in[1:0] = 2'b00; settle(); ext_in[1:0] = 2'b11; settle();
      rd(2'd3, d); chk("R6 both lines pending", d, 32'h3);
      wr(2'd3, 32'h0);
      rd(2'd3, d); chk("R6 writing zero keeps bits", d, 32'h3);
      wr(2'd3, 32'h1);
      rd(2'd3, d); chk("R6 clear only bit 0", d, 32'h2);
      wr(2'd3, 32'h2);
      rd(2'd3, d); chk("R6 clear bit 1", d, 32'h0);
   endtask

   task automatic t_collision();
      logic [31:0] d;
      set_pair(2, 4'd4);
      ext_in[5] = 1'b0; settle();
      wr(2'd3, 32'hFFFF_FFFF);
      ext_in[5] = 1'b1; settle();
      rd(2'd3, d); chk("R3 rising line 5", d, 32'h20);
      ext_in[5] = 1'b0; settle();
      ext_in[5] = 1'b1;
      @(negedge clk);
      wr(2'd3, 32'h20);
      rd(2'd3, d); chk("R9 event beats simultaneous clear", d, 32'h20);
      wr(2'd3, 32'h20);
      rd(2'd3, d); chk("R6 plain clear", d, 32'h0);
      set_pair(2, 4'd0);
      settle();
   endtask

   task automatic t_groups();
      logic [31:0] d;
      int lines [6] = '{3, 4, 11, 12, 19, 24};
      logic [31:0] exp_p = 32'h0;
      foreach (lines[k]) exp_p[lines[k]] = 1'b1;
      wr(2'd3, 32'hFFFF_FFFF);
      foreach (lines[k]) ext_in[lines[k]] = 1'b0;
      settle();
      foreach (lines[k]) ext_in[lines[k]] = 1'b1;
      settle();
      rd(2'd3, d); chk("R8 pending set for group edges", d, exp_p);
      chk("R7 all masked irq low", {28'h0, irq}, 32'h0);
      for (int k = 0; k < 6; k++) begin
         wr(2'd2, ~(32'h1 << lines[k]));
         #1 chk($sformatf("R8 line %0d drives its group", lines[k]), {28'h0, irq}, {28'h0, grp_bit(lines[k])});
      end
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd3, d); chk("R7 mask keeps pending bits", d, exp_p);
      wr(2'd2, 32'h0);
      #1 chk("R8 all groups active", {28'h0, irq}, 32'hF);
      wr(2'd3, 32'h0000_0008);
      #1 chk("R8 group 0 drops after clear", {28'h0, irq}, 32'hE);
      wr(2'd3, 32'h0000_0810);
      #1 chk("R8 group 1 drops after clear", {28'h0, irq}, 32'hC);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      cfg_sh[0] = '0; cfg_sh[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_latency();
      t_edge_codes();
      t_level();
      t_w1c();
      t_collision();
      t_groups();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule